// File: doc/BRIEF.md
# Ping-pong descriptor DMA engine

This block moves data for one channel at a time. Its instructions live in system memory as three-word structures: a source end pointer, a destination end pointer and a control word. Each channel owns two such structures, one in a primary table and one in an alternate table. A per-channel select bit chooses which table is read. When a request arrives for a channel, the engine fetches the active structure and checks it. It then copies a burst of items, rewinding each address from its end pointer by the number of items still left. Finally it writes the control word back with the count it has reached.

When the last item has moved, the engine marks the structure stopped and gives a one-cycle done pulse on that channel's bit. In ping-pong mode it then flips the channel's select bit and goes straight on with the other structure. Software can refill one half while the other half streams. A stopped structure ends the chain quietly.

Illegal control words and data addresses in the non-accessible low region (flash and ROM) raise an error pulse and stop the channel. All memory traffic uses a single request/acknowledge port.

Top module: `pingpong_dma`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `done`, `err` and every `alt_sel` bit are 0.
- R2: A request fetches the three words of channel c's structure by reads at T+16c+0, +4 and +8, in that order. T is `alt_base` when `alt_sel[c]` is 1 and `pri_base` otherwise. A request holds `mem_req` and its address steady until `mem_ack`.
- R3: Control word fields are: [31:30] destination increment, [29:28] destination size, [27:26] source increment, [25:24] source size, [17:14] burst exponent A, [13:4] items left minus one (n), and [2:0] mode. Mode 1 is basic, 3 is ping-pong and 0 is stopped.
- R4: Each item's address is the end pointer minus n·2^inc bytes, where n is the current items-left-minus-one. An increment code of 3 keeps the address fixed at the end pointer.
- R5: Size code 0 moves a byte, 1 a halfword and 2 a word. The source item is taken from its byte lane and written to the destination with the destination size. It is zero-extended or truncated as needed.
- R6: A request moves at most 2^A items. If items remain, the control word is written back with the new n and the same mode, and the engine goes idle. A later request resumes from there.
- R7: After the last item, the control word is written back with n=0 and mode 0. `done[c]` then pulses high for exactly one cycle, in the cycle after that write is acknowledged.
- R8: On completion of a ping-pong structure, `alt_sel[c]` toggles and the other structure is fetched without a new request. If that structure's mode is 0, the engine stops without a done pulse.
- R9: A request whose structure has mode 0 performs only the three fetch reads. It makes no data access, no write-back and no done pulse.
- R10: A size code of 3, or a mode other than 0, 1 or 3, makes no data access. The control word is written back with mode 0, and `err` pulses with no done.
- R11: A data address below `NOACC_LIMIT` (default 0x0010_0000) is never put on the bus. The engine pulses `err` and writes the control word back with mode 0 and n unchanged.
- R12: `alt_set[c]` sets `alt_sel[c]` and `alt_clr[c]` clears it; set wins when both are high. The new value is used by the next fetch.
- R13: `req_go` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_base | input | 32 | Primary structure table base |
| alt_base | input | 32 | Alternate structure table base |
| alt_set | input | NCH | Per-channel set of the alternate select |
| alt_clr | input | NCH | Per-channel clear of the alternate select |
| alt_sel | output | NCH | Current alternate select per channel |
| req_go | input | 1 | Transfer request pulse |
| req_ch | input | CHW | Channel of the request |
| busy | output | 1 | Engine not idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| mem_wdata | output | 32 | Write data, item replicated across lanes |
| mem_rdata | input | 32 | Read data word |
| mem_ack | input | 1 | Access completed |
| done | output | NCH | Per-channel completion pulse |
| err | output | 1 | Error pulse |

## Verification
The bench memory acknowledges one cycle after it sees a request, so each access takes two cycles, plus one for the state that leads to it. The done and error pulses come one cycle after the write-back acknowledge, and `busy` falls one cycle after that. For these reasons the bench does not predict absolute cycles for memory contents. It waits on falling edges until `busy` is low, and only then compares memory, the written-back control word and the pulse counters. A monitor samples on the falling edge. It logs each acknowledged access with its address and counts done and error pulses, so order and pulse width are checked as they happen.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;
  localparam logic [2:0] MODE_PP    = 3'd3;
  localparam logic [1:0] INC_HOLD   = 2'd3;
  localparam logic [1:0] SZ_BYTE    = 2'd0;
  localparam logic [1:0] SZ_HALF    = 2'd1;
  localparam logic [1:0] SZ_BAD     = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EVAL,
    ST_ITEM,
    ST_RD,
    ST_WR,
    ST_WB,
    ST_FIN
  } dma_state_e;

  typedef struct packed {
    logic [1:0] dinc;
    logic [1:0] dsize;
    logic [1:0] sinc;
    logic [1:0] ssize;
    logic [5:0] rsv_hi;
    logic [3:0] arb;
    logic [9:0] left_m1;
    logic       rsv_lo;
    logic [2:0] mode;
  } ctrl_t;

  // Address of the item that still has left_m1 items after it.
  function automatic logic [31:0] item_addr(input logic [31:0] end_ptr,
                                            input logic [9:0]  left_m1,
                                            input logic [1:0]  inc);
    logic [31:0] span;
    span = {22'd0, left_m1} << inc;
    return (inc == INC_HOLD) ? end_ptr : end_ptr - span;
  endfunction

  function automatic logic [31:0] lane_extract(input logic [31:0] word,
                                               input logic [1:0]  lo,
                                               input logic [1:0]  sz);
    logic [31:0] sh;
    sh = word >> {lo, 3'b000};
    case (sz)
      SZ_BYTE: return {24'd0, sh[7:0]};
      SZ_HALF: return {16'd0, sh[15:0]};
      default: return word;
    endcase
  endfunction

  function automatic logic [31:0] lane_place(input logic [31:0] item,
                                             input logic [1:0]  sz);
    case (sz)
      SZ_BYTE: return {4{item[7:0]}};
      SZ_HALF: return {2{item[15:0]}};
      default: return item;
    endcase
  endfunction

  function automatic logic mode_legal(input logic [2:0] m);
    return (m == MODE_BASIC) || (m == MODE_PP);
  endfunction

  function automatic logic addr_blocked(input logic [31:0] a,
                                        input logic [31:0] limit);
    return a < limit;
  endfunction

endpackage

// File: rtl/pp_addr_unit.sv
module pp_addr_unit
  import pp_dma_pkg::*;
#(
  parameter logic [31:0] NOACC_LIMIT = 32'h0010_0000
)(
  input  logic [31:0] src_end,
  input  logic [31:0] dst_end,
  input  logic [9:0]  left_m1,
  input  logic [1:0]  sinc,
  input  logic [1:0]  dinc,
  output logic [31:0] src_addr,
  output logic [31:0] dst_addr,
  output logic        src_blk,
  output logic        dst_blk
);

  always_comb begin
    src_addr = item_addr(src_end, left_m1, sinc);
    dst_addr = item_addr(dst_end, left_m1, dinc);
    src_blk  = addr_blocked(src_addr, NOACC_LIMIT);
    dst_blk  = addr_blocked(dst_addr, NOACC_LIMIT);
  end

endmodule

// File: rtl/pp_lane_unit.sv
module pp_lane_unit
  import pp_dma_pkg::*;
(
  input  logic [31:0] rdata,
  input  logic [1:0]  src_lo,
  input  logic [1:0]  ssize,
  input  logic [31:0] item,
  input  logic [1:0]  dsize,
  output logic [31:0] item_in,
  output logic [31:0] wdata
);

  always_comb begin
    item_in = lane_extract(rdata, src_lo, ssize);
    wdata   = lane_place(item, dsize);
  end

endmodule

// File: rtl/pp_alt_bank.sv
module pp_alt_bank #(
  parameter int NCH = 4,
  parameter int CHW = 2
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic           flip_en,
  input  logic [CHW-1:0] flip_ch,
  output logic [NCH-1:0] sel_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic bit_q;
    logic flip_here;
    assign flip_here = flip_en && (flip_ch == CHW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (set_i[c])   bit_q <= 1'b1;
      else if (clr_i[c])   bit_q <= 1'b0;
      else if (flip_here)  bit_q <= ~bit_q;
    end
    assign sel_o[c] = bit_q;

    AST_ALT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[c] |=> sel_o[c]); // R12
    AST_ALT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[c] && !set_i[c]) |=> !sel_o[c]); // R12
    AST_ALT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_here && !set_i[c] && !clr_i[c]) |=> (sel_o[c] != $past(sel_o[c]))); // R8
  end

endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
  import pp_dma_pkg::*;
#(
  parameter int          NCH         = 4,
  parameter int          STRIDE_LG   = 4,
  parameter logic [31:0] NOACC_LIMIT = 32'h0010_0000,
  localparam int         CHW         = (NCH > 1) ? $clog2(NCH) : 1
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    pri_base,
  input  logic [31:0]    alt_base,
  input  logic [NCH-1:0] alt_set,
  input  logic [NCH-1:0] alt_clr,
  output logic [NCH-1:0] alt_sel,
  input  logic           req_go,
  input  logic [CHW-1:0] req_ch,
  output logic           busy,
  output logic           mem_req,
  output logic           mem_we,
  output logic [31:0]    mem_addr,
  output logic [1:0]     mem_size,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_ack,
  output logic [NCH-1:0] done,
  output logic           err
);

  localparam int BW = 16;

  dma_state_e      state;
  logic [CHW-1:0]  ch_q;
  logic [1:0]      fidx_q;
  logic [31:0]     src_end_q;
  logic [31:0]     dst_end_q;
  ctrl_t           ctrl_q;
  logic [9:0]      left_q;
  logic [BW-1:0]   burst_q;
  logic [31:0]     item_q;
  logic            fin_cmp;
  logic            fin_err;

  // Named internal events
  logic [31:0] src_addr, dst_addr;
  logic        src_blk, dst_blk;
  logic [31:0] item_in, item_wdata;
  logic [31:0] tbl_base, desc_base, wb_word;
  logic        ev_item_done;
  logic        ev_last_item;
  logic        ev_burst_end;
  logic        ev_bad_ctrl;
  logic        done_pulse;
  logic        flip_en;
  ctrl_t       wb_ctrl;

  pp_addr_unit #(.NOACC_LIMIT(NOACC_LIMIT)) u_addr (
    .src_end (src_end_q),
    .dst_end (dst_end_q),
    .left_m1 (left_q),
    .sinc    (ctrl_q.sinc),
    .dinc    (ctrl_q.dinc),
    .src_addr(src_addr),
    .dst_addr(dst_addr),
    .src_blk (src_blk),
    .dst_blk (dst_blk)
  );

  pp_lane_unit u_lane (
    .rdata  (mem_rdata),
    .src_lo (src_addr[1:0]),
    .ssize  (ctrl_q.ssize),
    .item   (item_q),
    .dsize  (ctrl_q.dsize),
    .item_in(item_in),
    .wdata  (item_wdata)
  );

  pp_alt_bank #(.NCH(NCH), .CHW(CHW)) u_alt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (alt_set),
    .clr_i  (alt_clr),
    .flip_en(flip_en),
    .flip_ch(ch_q),
    .sel_o  (alt_sel)
  );

  assign tbl_base  = alt_sel[ch_q] ? alt_base : pri_base;
  assign desc_base = tbl_base + ({{(32-CHW){1'b0}}, ch_q} << STRIDE_LG);

  assign ev_item_done = (state == ST_WR) && mem_ack;
  assign ev_last_item = ev_item_done && (left_q == 10'd0);
  assign ev_burst_end = ev_item_done && (left_q != 10'd0) && (burst_q == BW'(1));
  assign ev_bad_ctrl  = !mode_legal(ctrl_q.mode) ||
                        (ctrl_q.ssize == SZ_BAD) || (ctrl_q.dsize == SZ_BAD);
  assign done_pulse   = (state == ST_FIN) && fin_cmp && !fin_err;
  assign flip_en      = done_pulse && (ctrl_q.mode == MODE_PP);

  always_comb begin
    wb_ctrl         = ctrl_q;
    wb_ctrl.left_m1 = left_q;
    if (fin_cmp || fin_err) wb_ctrl.mode = MODE_STOP;
    wb_word = wb_ctrl;
  end

  // Bus drive
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'd0;
    mem_size  = 2'd2;
    mem_wdata = 32'd0;
    unique case (state)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_base + {28'd0, fidx_q, 2'b00};
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_addr;
        mem_size = ctrl_q.ssize;
      end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_addr;
        mem_size  = ctrl_q.dsize;
        mem_wdata = item_wdata;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_base + 32'd8;
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ch_q      <= '0;
      fidx_q    <= 2'd0;
      src_end_q <= 32'd0;
      dst_end_q <= 32'd0;
      ctrl_q    <= '0;
      left_q    <= 10'd0;
      burst_q   <= '0;
      item_q    <= 32'd0;
      fin_cmp   <= 1'b0;
      fin_err   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_go) begin
          ch_q    <= req_ch;
          fidx_q  <= 2'd0;
          fin_cmp <= 1'b0;
          fin_err <= 1'b0;
          state   <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack) begin
          case (fidx_q)
            2'd0:    src_end_q <= mem_rdata;
            2'd1:    dst_end_q <= mem_rdata;
            default: begin
              ctrl_q <= ctrl_t'(mem_rdata);
              left_q <= mem_rdata[13:4];
            end
          endcase
          if (fidx_q == 2'd2) state <= ST_EVAL;
          else                fidx_q <= fidx_q + 2'd1;
        end
        ST_EVAL: begin
          burst_q <= BW'(1) << ctrl_q.arb;
          if (ctrl_q.mode == MODE_STOP) state <= ST_IDLE;
          else if (ev_bad_ctrl) begin
            fin_err <= 1'b1;
            state   <= ST_WB;
          end else state <= ST_ITEM;
        end
        ST_ITEM: begin
          if (src_blk || dst_blk) begin
            fin_err <= 1'b1;
            state   <= ST_WB;
          end else state <= ST_RD;
        end
        ST_RD: if (mem_ack) begin
          item_q <= item_in;
          state  <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          if (left_q == 10'd0) begin
            fin_cmp <= 1'b1;
            state   <= ST_WB;
          end else begin
            left_q <= left_q - 10'd1;
            if (burst_q == BW'(1)) state <= ST_WB;
            else begin
              burst_q <= burst_q - BW'(1);
              state   <= ST_ITEM;
            end
          end
        end
        ST_WB: if (mem_ack) state <= ST_FIN;
        ST_FIN: begin
          if (fin_cmp && !fin_err && ctrl_q.mode == MODE_PP) begin
            fidx_q  <= 2'd0;
            fin_cmp <= 1'b0;
            state   <= ST_FETCH;
          end else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = done_pulse ? ({{(NCH-1){1'b0}}, 1'b1} << ch_q) : '0;
  assign err  = (state == ST_FIN) && fin_err;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!mem_req && done == '0 && !err)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size != SZ_BAD)); // R10
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (done != '0) |-> $past(state == ST_WB && mem_ack)); // R7
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done != '0) |=> (done == '0)); // R7
  AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done == '0)); // R10
  AST_NO_BLOCKED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (state == ST_RD || state == ST_WR)) |-> (mem_addr >= NOACC_LIMIT)); // R11
  AST_FINAL_WB_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB && fin_cmp && mem_req) |-> (mem_wdata[2:0] == MODE_STOP && mem_wdata[13:4] == 10'd0)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(ch_q)); // R13

endmodule

// File: tb/pingpong_dma_bench.sv
module pingpong_dma_bench;

  localparam int          NCH   = 4;
  localparam logic [31:0] PRI   = 32'h2000_0000;
  localparam logic [31:0] ALT   = 32'h2000_0100;
  localparam logic [31:0] LIMIT = 32'h0010_0000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] alt_set = '0, alt_clr = '0, alt_sel;
  logic           req_go = 1'b0;
  logic [1:0]     req_ch = 2'd0;
  logic           busy, mem_req, mem_we, mem_ack, err;
  logic [31:0]    mem_addr, mem_wdata, mem_rdata;
  logic [1:0]     mem_size;
  logic [NCH-1:0] done;

  always #5 clk = ~clk;

  pingpong_dma #(.NCH(NCH), .NOACC_LIMIT(LIMIT)) u_pingpong_dma (
    .clk(clk), .rst_n(rst_n), .pri_base(PRI), .alt_base(ALT),
    .alt_set(alt_set), .alt_clr(alt_clr), .alt_sel(alt_sel),
    .req_go(req_go), .req_ch(req_ch), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done), .err(err)
  );

  logic [31:0] mem     [0:4095];
  logic [31:0] exp_mem [0:4095];

  function automatic int widx(input logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  // Bench memory: ack one cycle after request, byte enables from size and lane
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        logic [31:0] w;
        logic [3:0]  be;
        w  = mem[widx(mem_addr)];
        be = (mem_size == 2'd0) ? (4'b0001 << mem_addr[1:0]) :
             (mem_size == 2'd1) ? (4'b0011 << {mem_addr[1], 1'b0}) : 4'hF;
        for (int b = 0; b < 4; b++) if (be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
        mem[widx(mem_addr)] = w;
      end else mem_rdata <= mem[widx(mem_addr)];
    end else mem_ack <= 1'b0;
  end

  // Monitor on the falling edge
  logic [31:0] log_addr [0:255];
  int lcnt = 0, low_hits = 0, err_cnt = 0, wide_pulse = 0;
  int done_cnt [NCH];
  logic [NCH-1:0] done_prev = '0;
  initial for (int c = 0; c < NCH; c++) done_cnt[c] = 0;

  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_ack) begin
      if (lcnt < 256) log_addr[lcnt] = mem_addr;
      lcnt = lcnt + 1;
      if (mem_addr < LIMIT) low_hits = low_hits + 1;
    end
    for (int c = 0; c < NCH; c++) if (done[c]) done_cnt[c] = done_cnt[c] + 1;
    if (done != '0 && done_prev != '0) wide_pulse = wide_pulse + 1;
    done_prev = done;
    if (err) err_cnt = err_cnt + 1;
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input int di, input int ds, input int si,
                                          input int ss, input int arb, input int nm1,
                                          input int mode);
    return {di[1:0], ds[1:0], si[1:0], ss[1:0], 6'd0, arb[3:0], nm1[9:0], 1'b0, mode[2:0]};
  endfunction

  function automatic logic [31:0] finished(input logic [31:0] c);
    return {c[31:14], 10'd0, c[3], 3'd0};
  endfunction

  function automatic logic [31:0] at_item(input logic [31:0] e, input int n, input logic [1:0] inc);
    if (inc == 2'd3) return e;
    return e - 32'(n) * (32'd1 << inc);
  endfunction

  function automatic logic [31:0] get_item(input logic [31:0] w, input logic [1:0] lo,
                                           input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'd0, w[8*lo +: 8]};
      2'd1:    return {16'd0, w[16*lo[1] +: 16]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] put_item(input logic [31:0] w, input logic [1:0] lo,
                                           input logic [1:0] sz, input logic [31:0] v);
    logic [31:0] r;
    r = w;
    case (sz)
      2'd0:    r[8*lo +: 8] = v[7:0];
      2'd1:    r[16*lo[1] +: 16] = v[15:0];
      default: r = v;
    endcase
    return r;
  endfunction

  task automatic model(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c,
                       input int first_n, input int items);
    for (int k = 0; k < items; k++) begin
      logic [31:0] sa, da, v;
      sa = at_item(s, first_n - k, c[27:26]);
      da = at_item(d, first_n - k, c[31:30]);
      v  = get_item(exp_mem[widx(sa)], sa[1:0], c[25:24]);
      exp_mem[widx(da)] = put_item(exp_mem[widx(da)], da[1:0], c[29:28], v);
    end
  endtask

  task automatic put_desc(input logic [31:0] base, input int ch, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] c);
    mem[widx(base + 32'(ch) * 16)]     = s;
    mem[widx(base + 32'(ch) * 16 + 4)] = d;
    mem[widx(base + 32'(ch) * 16 + 8)] = c;
  endtask

  function automatic logic [31:0] ctrl_of(input logic [31:0] base, input int ch);
    return mem[widx(base + 32'(ch) * 16 + 8)];
  endfunction

  task automatic wait_idle();
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (!busy) return;
    end
    check(1'b0, "R1", "engine stayed busy", {31'd0, busy}, 32'd0);
  endtask

  task automatic pulse_go(input int ch);
    @(negedge clk);
    req_ch = 2'(ch);
    req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
  endtask

  task automatic go(input int ch);
    pulse_go(ch);
    wait_idle();
  endtask

  task automatic cmp_data(input string tag);
    int bad;
    bad = -1;
    for (int i = 1024; i < 3072; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) check(1'b1, tag, "data", 32'd0, 32'd0);
    else check(1'b0, tag, $sformatf("data word %0d", bad), mem[bad], exp_mem[bad]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] c, s, d;
    int d0, e0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
    for (int i = 1024; i < 2048; i++) mem[i] = $urandom;
    for (int i = 0; i < 4096; i++) exp_mem[i] = mem[i];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, mem_req, done, err, alt_sel} == '0, "R1", "reset state",
          {20'd0, busy, mem_req, done, err, alt_sel}, 32'd0);

    // R2 R3 R4 R7: basic word copy, 4 items
    c = mk_ctrl(2, 2, 2, 2, 4, 3, 1);
    put_desc(PRI, 0, 32'h2000_100C, 32'h2000_200C, c);
    lcnt = 0;
    go(0);
    model(32'h2000_100C, 32'h2000_200C, c, 3, 4);
    check(log_addr[0] == PRI && log_addr[1] == PRI + 4 && log_addr[2] == PRI + 8,
          "R2", "fetch order", log_addr[2], PRI + 8);
    check(log_addr[3] == 32'h2000_1000, "R4", "first source address", log_addr[3], 32'h2000_1000);
    check(log_addr[4] == 32'h2000_2000, "R4", "first destination address", log_addr[4], 32'h2000_2000);
    cmp_data("R3");
    check(ctrl_of(PRI, 0) == finished(c), "R7", "final control word", ctrl_of(PRI, 0), finished(c));
    check(done_cnt[0] == 1 && wide_pulse == 0, "R7", "single done pulse", 32'(done_cnt[0]), 32'd1);

    // R4 R5: byte source held fixed, halfword destination
    c = mk_ctrl(1, 1, 3, 0, 4, 2, 1);
    put_desc(PRI, 1, 32'h2000_1101, 32'h2000_2104, c);
    lcnt = 0;
    go(1);
    model(32'h2000_1101, 32'h2000_2104, c, 2, 3);
    check(log_addr[3] == 32'h2000_1101 && log_addr[5] == 32'h2000_1101, "R4",
          "held source address", log_addr[5], 32'h2000_1101);
    cmp_data("R5");

    // R6: bursts of 2 items, 5 items total
    c = mk_ctrl(2, 2, 2, 2, 1, 4, 1);
    put_desc(PRI, 2, 32'h2000_1210, 32'h2000_2210, c);
    go(2);
    model(32'h2000_1210, 32'h2000_2210, c, 4, 2);
    check(ctrl_of(PRI, 2) == mk_ctrl(2, 2, 2, 2, 1, 2, 1), "R6", "control after burst 1",
          ctrl_of(PRI, 2), mk_ctrl(2, 2, 2, 2, 1, 2, 1));
    cmp_data("R6");
    check(done_cnt[2] == 0, "R6", "no done mid-transfer", 32'(done_cnt[2]), 32'd0);
    go(2);
    model(32'h2000_1210, 32'h2000_2210, c, 2, 2);
    check(ctrl_of(PRI, 2) == mk_ctrl(2, 2, 2, 2, 1, 0, 1), "R6", "control after burst 2",
          ctrl_of(PRI, 2), mk_ctrl(2, 2, 2, 2, 1, 0, 1));
    go(2);
    model(32'h2000_1210, 32'h2000_2210, c, 0, 1);
    cmp_data("R6");
    check(done_cnt[2] == 1 && ctrl_of(PRI, 2) == finished(c), "R7", "resumed completion",
          ctrl_of(PRI, 2), finished(c));

    // R8: ping-pong primary then alternate, then stopped primary ends the chain
    c = mk_ctrl(2, 2, 2, 2, 4, 1, 3);
    put_desc(PRI, 3, 32'h2000_1304, 32'h2000_2304, c);
    put_desc(ALT, 3, 32'h2000_1348, 32'h2000_2348, mk_ctrl(2, 2, 2, 2, 4, 2, 3));
    go(3);
    model(32'h2000_1304, 32'h2000_2304, c, 1, 2);
    model(32'h2000_1348, 32'h2000_2348, mk_ctrl(2, 2, 2, 2, 4, 2, 3), 2, 3);
    cmp_data("R8");
    check(done_cnt[3] == 2, "R8", "two halves done", 32'(done_cnt[3]), 32'd2);
    check(alt_sel[3] == 1'b0, "R8", "select flipped twice", {31'd0, alt_sel[3]}, 32'd0);
    check(ctrl_of(ALT, 3) == finished(mk_ctrl(2, 2, 2, 2, 4, 2, 3)), "R8", "alternate stopped",
          ctrl_of(ALT, 3), finished(mk_ctrl(2, 2, 2, 2, 4, 2, 3)));

    // R9: stopped structure
    lcnt = 0;
    d0 = done_cnt[0];
    go(0);
    check(lcnt == 3 && done_cnt[0] == d0, "R9", "only fetches on stopped", 32'(lcnt), 32'd3);

    // R10: illegal size code
    c = mk_ctrl(2, 2, 2, 3, 4, 1, 1);
    put_desc(PRI, 1, 32'h2000_1400, 32'h2000_2400, c);
    lcnt = 0;
    e0 = err_cnt;
    go(1);
    check(err_cnt == e0 + 1 && lcnt == 4, "R10", "size 3 error", 32'(lcnt), 32'd4);
    check(ctrl_of(PRI, 1) == {c[31:3], 3'd0}, "R10", "stopped on error", ctrl_of(PRI, 1),
          {c[31:3], 3'd0});
    c = mk_ctrl(2, 2, 2, 2, 4, 1, 5);
    put_desc(PRI, 1, 32'h2000_1400, 32'h2000_2400, c);
    go(1);
    check(err_cnt == e0 + 2, "R10", "illegal mode error", 32'(err_cnt), 32'(e0 + 2));
    cmp_data("R10");

    // R11: source in the non-accessible region
    c = mk_ctrl(2, 2, 2, 2, 4, 2, 1);
    put_desc(PRI, 2, 32'h0000_1000, 32'h2000_2440, c);
    d0 = done_cnt[2];
    go(2);
    check(low_hits == 0 && err_cnt == e0 + 3, "R11", "blocked access", 32'(low_hits), 32'd0);
    check(ctrl_of(PRI, 2) == {c[31:3], 3'd0} && done_cnt[2] == d0, "R11", "count kept",
          ctrl_of(PRI, 2), {c[31:3], 3'd0});

    // R12: set and clear together, then fetch from the alternate table
    @(negedge clk);
    alt_set = 4'b0001;
    alt_clr = 4'b0001;
    @(negedge clk);
    alt_set = '0;
    alt_clr = '0;
    check(alt_sel[0] == 1'b1, "R12", "set wins", {31'd0, alt_sel[0]}, 32'd1);
    c = mk_ctrl(2, 2, 2, 2, 4, 1, 1);
    put_desc(ALT, 0, 32'h2000_1504, 32'h2000_2504, c);
    lcnt = 0;
    go(0);
    model(32'h2000_1504, 32'h2000_2504, c, 1, 2);
    check(log_addr[0] == ALT, "R12", "alternate fetch", log_addr[0], ALT);
    cmp_data("R12");
    @(negedge clk);
    alt_clr = 4'b0001;
    @(negedge clk);
    alt_clr = '0;
    check(alt_sel[0] == 1'b0, "R12", "clear", {31'd0, alt_sel[0]}, 32'd0);

    // R13: a second request while busy is dropped
    c = mk_ctrl(2, 2, 2, 2, 4, 7, 1);
    put_desc(PRI, 1, 32'h2000_161C, 32'h2000_261C, c);
    put_desc(PRI, 2, 32'h2000_1704, 32'h2000_2704, mk_ctrl(2, 2, 2, 2, 4, 1, 1));
    d0 = done_cnt[2];
    pulse_go(1);
    pulse_go(2);
    wait_idle();
    model(32'h2000_161C, 32'h2000_261C, c, 7, 8);
    cmp_data("R13");
    check(ctrl_of(PRI, 2) == mk_ctrl(2, 2, 2, 2, 4, 1, 1) && done_cnt[2] == d0, "R13",
          "request while busy ignored", ctrl_of(PRI, 2), mk_ctrl(2, 2, 2, 2, 4, 1, 1));

    // Random transfers: R3 R4 R5
    for (int it = 0; it < 24; it++) begin
      int ch, ss, ds, si, di, n;
      ch = $urandom_range(0, 3);
      ss = $urandom_range(0, 2);
      ds = $urandom_range(0, 2);
      si = $urandom_range(0, 1) ? 3 : ss + $urandom_range(0, 2 - ss);
      di = $urandom_range(0, 1) ? 3 : ds + $urandom_range(0, 2 - ds);
      n  = $urandom_range(1, 16);
      s  = 32'h2000_1800 + ($urandom_range(0, 63) << 2) + ($urandom_range(0, 3) & (ss == 0 ? 3 : ss == 1 ? 2 : 0));
      d  = 32'h2000_2800 + ($urandom_range(0, 63) << 2) + ($urandom_range(0, 3) & (ds == 0 ? 3 : ds == 1 ? 2 : 0));
      c  = mk_ctrl(di, ds, si, ss, 4, n - 1, 1);
      put_desc(PRI, ch, s, d, c);
      go(ch);
      model(s, d, c, n - 1, n);
      cmp_data("R5");
      check(ctrl_of(PRI, ch) == finished(c), "R4", "random final control", ctrl_of(PRI, ch),
            finished(c));
    end
    check(low_hits == 0 && wide_pulse == 0, "R7", "no stray accesses or wide pulses",
          32'(low_hits + wide_pulse), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule